// File: doc/BRIEF.md
# ECC Memory Sweep Engine

This block runs beside a memory controller whose array holds ECC-protected words. Once started with correction enabled, it fills every location with a write that carries valid check bits. It then settles into an endless background loop. In that loop it waits a programmed interval, reads one location, and inspects the error flags that an external ECC checker reports for that read. A location that shows a correctable error is written back, so the controller's corrected data replaces the bad word. An uncorrectable error is only counted.

All memory traffic goes through a single request/grant command port. Each request is held until the controller grants it. The engine does not produce data or check bits. A write request tells the controller either to store a freshly encoded word during the fill pass or to store the corrected word during a fix-up. The interval between reads is the programmed period multiplied by 256 controller clocks. The number of address bits walked can be programmed, and a setting of zero selects the widest address the memory supports.

Top module: `ecc_sweep_engine`

## Requirements
- R1: While `ecc_en` is low the engine issues no request, clears `init_done` and ignores `start`. If `ecc_en` falls mid-operation, `cmd_req` is low from the next cycle on.
- R2: When `start` is seen in the idle state with `ecc_en` high, the engine issues write requests (`cmd_write`=1) to addresses 0, 1, … up to the last address, in that order. Each request holds its address until `cmd_gnt`.
- R3: `cfg_addr_bits` is sampled when `start` is accepted. A value of 0, or a value above `MAX_ADDR_W`, means `MAX_ADDR_W` bits. The fill pass then covers exactly 2^bits locations.
- R4: `init_done` rises in the cycle after the last fill write is granted. It stays high until `ecc_en` falls. No read request appears before it.
- R5: After the fill pass completes, and after each scrubbed location completes, `cmd_req` stays low for exactly max(`cfg_period`×256, 1) cycles. `cfg_period` is sampled in the cycle the wait begins.
- R6: A scrub read is a request with `cmd_write`=0 at the current address, held until granted. The engine then waits, with no request, for `rd_valid`.
- R7: A response with `rd_single`=1 and `rd_double`=0 increments `ce_count`. It is followed by a write request to the same address before the engine moves on.
- R8: A response with both flags clear moves the engine to the next address with no write.
- R9: A response with `rd_double`=1, whatever the value of `rd_single`, increments `ue_count` and is never written back.
- R10: After the last address the scrub address wraps to 0, `pass_count` increments, and scrubbing continues.
- R11: After reset `cmd_req`, `init_done`, `ce_count`, `ue_count` and `pass_count` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ecc_en | input | 1 | ECC correction enabled; the engine runs only while high |
| start | input | 1 | Begin the fill pass (accepted only when idle) |
| cfg_addr_bits | input | SEL_W | Address bits to walk; 0 selects the maximum |
| cfg_period | input | PERIOD_W | Scrub interval in units of 256 clocks |
| cmd_req | output | 1 | Command request toward the controller |
| cmd_write | output | 1 | 1 = write (fill or fix-up), 0 = scrub read |
| cmd_addr | output | MAX_ADDR_W | Command address |
| cmd_gnt | input | 1 | Controller accepts the current command |
| rd_valid | input | 1 | Scrub read response is present |
| rd_single | input | 1 | Checker flag: correctable error |
| rd_double | input | 1 | Checker flag: uncorrectable error |
| init_done | output | 1 | Fill pass complete |
| ce_count | output | CNT_W | Correctable errors seen (saturating) |
| ue_count | output | CNT_W | Uncorrectable errors seen (saturating) |
| pass_count | output | CNT_W | Completed scrub passes (saturating) |

## Verification
A wrong phase register shows at the command port in the very next cycle: a request appears or vanishes, or its write flag flips. A wrong address, or a wrong last-address mask, shows at the next request. At worst it appears one scrub interval later as an out-of-order or missed wrap. A timer off by one shifts the next read request by a cycle. Comparing against the model on every clock therefore catches it within one interval. Misrouted error flags show as a counter step, or a missing or extra fix-up write, within one cycle of the response.

// File: rtl/sweep_pkg.sv
package sweep_pkg;

   typedef enum logic [2:0] {
      PH_IDLE = 3'd0,
      PH_FILL = 3'd1,
      PH_WAIT = 3'd2,
      PH_READ = 3'd3,
      PH_RESP = 3'd4,
      PH_FIX  = 3'd5
   } sweep_phase_t;

   function automatic logic phase_requests(input sweep_phase_t ph);
      return (ph == PH_FILL) || (ph == PH_READ) || (ph == PH_FIX);
   endfunction

   function automatic logic phase_writes(input sweep_phase_t ph);
      return (ph == PH_FILL) || (ph == PH_FIX);
   endfunction

endpackage

// File: rtl/sweep_interval_timer.sv
module sweep_interval_timer #(
   parameter int PERIOD_W   = 8,
   parameter int TICK_SHIFT = 8
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                load,
   input  logic [PERIOD_W-1:0] period,
   output logic                expired
);

   localparam int TMR_W = PERIOD_W + TICK_SHIFT;

   logic [TMR_W-1:0] cnt_q;
   logic [TMR_W-1:0] gap;
   logic [TMR_W-1:0] load_val;

   always_comb begin
      gap = TMR_W'(period) << TICK_SHIFT;
      load_val = (gap == '0) ? '0 : gap - TMR_W'(1);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (load) begin
         cnt_q <= load_val;
      end else if (cnt_q != '0) begin
         cnt_q <= cnt_q - TMR_W'(1);
      end
   end

   assign expired = (cnt_q == '0);

endmodule

// File: rtl/sweep_addr_walker.sv
module sweep_addr_walker #(
   parameter int MAX_ADDR_W = 10,
   parameter int SEL_W      = 4
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  capture,
   input  logic [SEL_W-1:0]      cfg_bits,
   input  logic                  clear,
   input  logic                  step,
   output logic [MAX_ADDR_W-1:0] addr,
   output logic                  at_last
);

   logic [MAX_ADDR_W-1:0] addr_q;
   logic [MAX_ADDR_W-1:0] last_q;
   logic [MAX_ADDR_W-1:0] mask;
   int                    eff;

   always_comb begin
      eff = int'({{(32-SEL_W){1'b0}}, cfg_bits});
      if (eff == 0 || eff > MAX_ADDR_W) eff = MAX_ADDR_W;
      for (int i = 0; i < MAX_ADDR_W; i++) begin
         mask[i] = (i < eff);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr_q <= '0;
         last_q <= '1;
      end else if (capture) begin
         addr_q <= '0;
         last_q <= mask;
      end else if (clear) begin
         addr_q <= '0;
      end else if (step) begin
         addr_q <= (addr_q == last_q) ? '0 : addr_q + MAX_ADDR_W'(1);
      end
   end

   assign addr    = addr_q;
   assign at_last = (addr_q == last_q);

endmodule

// File: rtl/sweep_event_counter.sv
module sweep_event_counter #(
   parameter int CNT_W    = 16,
   parameter bit SATURATE = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             inc,
   output logic [CNT_W-1:0] count
);

   logic [CNT_W-1:0] cnt_q;

   generate
      if (SATURATE) begin : g_sat
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                   cnt_q <= '0;
            else if (inc && cnt_q != '1) cnt_q <= cnt_q + CNT_W'(1);
         end
      end else begin : g_wrap
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)   cnt_q <= '0;
            else if (inc) cnt_q <= cnt_q + CNT_W'(1);
         end
      end
   endgenerate

   assign count = cnt_q;

endmodule

// File: rtl/ecc_sweep_engine.sv
module ecc_sweep_engine #(
   parameter int MAX_ADDR_W = 10,
   parameter int PERIOD_W   = 8,
   parameter int TICK_SHIFT = 8,
   parameter int CNT_W      = 16,
   parameter bit SATURATE   = 1'b1,
   parameter int SEL_W      = $clog2(MAX_ADDR_W + 1)
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  ecc_en,
   input  logic                  start,
   input  logic [SEL_W-1:0]      cfg_addr_bits,
   input  logic [PERIOD_W-1:0]   cfg_period,
   output logic                  cmd_req,
   output logic                  cmd_write,
   output logic [MAX_ADDR_W-1:0] cmd_addr,
   input  logic                  cmd_gnt,
   input  logic                  rd_valid,
   input  logic                  rd_single,
   input  logic                  rd_double,
   output logic                  init_done,
   output logic [CNT_W-1:0]      ce_count,
   output logic [CNT_W-1:0]      ue_count,
   output logic [CNT_W-1:0]      pass_count
);
   import sweep_pkg::*;

   generate
      if (MAX_ADDR_W < 1 || MAX_ADDR_W > 30) begin : g_bad_addr
         $error("MAX_ADDR_W must lie in 1..30");
      end
      if (SEL_W < $clog2(MAX_ADDR_W + 1) || SEL_W > 31) begin : g_bad_sel
         $error("SEL_W too narrow for MAX_ADDR_W");
      end
      if (PERIOD_W < 1 || TICK_SHIFT < 0 || PERIOD_W + TICK_SHIFT > 31) begin : g_bad_tmr
         $error("timer width out of range");
      end
      if (CNT_W < 1) begin : g_bad_cnt
         $error("CNT_W must be positive");
      end
   endgenerate

   sweep_phase_t phase_q, phase_d;
   logic         done_q, done_d;
   logic         capture, clear_addr, step_addr, tmr_load;
   logic         ce_inc, ue_inc, pass_inc;
   logic         expired, at_last;
   logic [MAX_ADDR_W-1:0] addr;

   always_comb begin
      phase_d    = phase_q;
      done_d     = done_q;
      capture    = 1'b0;
      clear_addr = 1'b0;
      step_addr  = 1'b0;
      tmr_load   = 1'b0;
      ce_inc     = 1'b0;
      ue_inc     = 1'b0;
      pass_inc   = 1'b0;
      if (!ecc_en) begin
         phase_d = PH_IDLE;
         done_d  = 1'b0;
      end else begin
         unique case (phase_q)
            PH_IDLE: begin
               if (start) begin
                  capture = 1'b1;
                  phase_d = PH_FILL;
               end
            end
            PH_FILL: begin
               if (cmd_gnt) begin
                  if (at_last) begin
                     done_d     = 1'b1;
                     clear_addr = 1'b1;
                     tmr_load   = 1'b1;
                     phase_d    = PH_WAIT;
                  end else begin
                     step_addr = 1'b1;
                  end
               end
            end
            PH_WAIT: begin
               if (expired) phase_d = PH_READ;
            end
            PH_READ: begin
               if (cmd_gnt) phase_d = PH_RESP;
            end
            PH_RESP: begin
               if (rd_valid) begin
                  if (rd_double) begin
                     ue_inc    = 1'b1;
                     step_addr = 1'b1;
                     pass_inc  = at_last;
                     tmr_load  = 1'b1;
                     phase_d   = PH_WAIT;
                  end else if (rd_single) begin
                     ce_inc  = 1'b1;
                     phase_d = PH_FIX;
                  end else begin
                     step_addr = 1'b1;
                     pass_inc  = at_last;
                     tmr_load  = 1'b1;
                     phase_d   = PH_WAIT;
                  end
               end
            end
            PH_FIX: begin
               if (cmd_gnt) begin
                  step_addr = 1'b1;
                  pass_inc  = at_last;
                  tmr_load  = 1'b1;
                  phase_d   = PH_WAIT;
               end
            end
            default: phase_d = PH_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q <= PH_IDLE;
         done_q  <= 1'b0;
      end else begin
         phase_q <= phase_d;
         done_q  <= done_d;
      end
   end

   sweep_interval_timer #(
      .PERIOD_W   (PERIOD_W),
      .TICK_SHIFT (TICK_SHIFT)
   ) u_timer (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (tmr_load),
      .period  (cfg_period),
      .expired (expired)
   );

   sweep_addr_walker #(
      .MAX_ADDR_W (MAX_ADDR_W),
      .SEL_W      (SEL_W)
   ) u_walker (
      .clk      (clk),
      .rst_n    (rst_n),
      .capture  (capture),
      .cfg_bits (cfg_addr_bits),
      .clear    (clear_addr),
      .step     (step_addr),
      .addr     (addr),
      .at_last  (at_last)
   );

   logic [2:0]             inc_vec;
   logic [2:0][CNT_W-1:0]  cnt_vec;

   assign inc_vec = {pass_inc, ue_inc, ce_inc};

   generate
      for (genvar k = 0; k < 3; k++) begin : g_cnt
         sweep_event_counter #(
            .CNT_W    (CNT_W),
            .SATURATE (SATURATE)
         ) u_cnt (
            .clk   (clk),
            .rst_n (rst_n),
            .inc   (inc_vec[k]),
            .count (cnt_vec[k])
         );
      end
   endgenerate

   assign ce_count   = cnt_vec[0];
   assign ue_count   = cnt_vec[1];
   assign pass_count = cnt_vec[2];

   assign cmd_req   = phase_requests(phase_q);
   assign cmd_write = phase_writes(phase_q);
   assign cmd_addr  = addr;
   assign init_done = done_q;

endmodule

// File: rtl/ecc_sweep_checks.sv
module ecc_sweep_checks #(
   parameter int MAX_ADDR_W = 10,
   parameter int CNT_W      = 16
) (
   input logic                  clk,
   input logic                  rst_n,
   input logic                  ecc_en,
   input logic                  cmd_req,
   input logic                  cmd_write,
   input logic [MAX_ADDR_W-1:0] cmd_addr,
   input logic                  cmd_gnt,
   input logic                  rd_valid,
   input logic                  rd_single,
   input logic                  rd_double,
   input logic                  init_done,
   input logic [CNT_W-1:0]      ce_count,
   input logic [CNT_W-1:0]      ue_count
);

   assert_off_no_req_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !ecc_en |=> !cmd_req);

   assert_req_held_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_req && !cmd_gnt && ecc_en) |=> (cmd_req && $stable(cmd_addr) && $stable(cmd_write)));

   assert_no_early_read_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_req && !cmd_write) |-> init_done);

   assert_done_after_grant_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(init_done) |-> $past(cmd_req && cmd_write && cmd_gnt));

   assert_ce_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (ce_count != $past(ce_count)) |-> $past(rd_valid && rd_single && !rd_double));

   assert_ue_no_fix_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (ue_count != $past(ue_count)) |-> !cmd_req);

endmodule

bind ecc_sweep_engine ecc_sweep_checks #(
   .MAX_ADDR_W (MAX_ADDR_W),
   .CNT_W      (CNT_W)
) u_checks (.*);

// File: tb/sim_ecc_sweep_engine.sv
module sim_ecc_sweep_engine;

   localparam int CLK_PERIOD = 10;
   localparam int MAXW  = 10;
   localparam int PW    = 8;
   localparam int CW    = 16;
   localparam int SW    = 4;
   localparam int WATCHDOG = 150000;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          ecc_en = 1'b0;
   logic          start = 1'b0;
   logic [SW-1:0] cfg_addr_bits = 4'd3;
   logic [PW-1:0] cfg_period = 8'd1;
   logic          cmd_req, cmd_write, cmd_gnt = 1'b0;
   logic [MAXW-1:0] cmd_addr;
   logic          rd_valid = 1'b0, rd_single = 1'b0, rd_double = 1'b0;
   logic          init_done;
   logic [CW-1:0] ce_count, ue_count, pass_count;

   always #(CLK_PERIOD/2) clk = ~clk;

   ecc_sweep_engine u0 (
      .clk(clk), .rst_n(rst_n), .ecc_en(ecc_en), .start(start),
      .cfg_addr_bits(cfg_addr_bits), .cfg_period(cfg_period),
      .cmd_req(cmd_req), .cmd_write(cmd_write), .cmd_addr(cmd_addr),
      .cmd_gnt(cmd_gnt), .rd_valid(rd_valid), .rd_single(rd_single),
      .rd_double(rd_double), .init_done(init_done), .ce_count(ce_count),
      .ue_count(ue_count), .pass_count(pass_count)
   );

   int n_checks = 0;
   int n_fail = 0;
   bit finished = 0;

   task automatic chk(input string tag, input string what, input int act, input int exp);
      n_checks++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
      end
   endtask

   // Behavioural reference: 0 idle,1 fill,2 wait,3 read,4 resp,5 fix
   int m_ph = 0, m_addr = 0, m_last = 7, m_tmr = 0;
   int m_ce = 0, m_ue = 0, m_pass = 0;
   bit m_done = 0;

   function automatic int gap_of(input int p);
      int g;
      g = p * 256;
      return (g == 0) ? 1 : g;
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         m_ph = 0; m_addr = 0; m_last = (1 << MAXW) - 1; m_tmr = 0;
         m_ce = 0; m_ue = 0; m_pass = 0; m_done = 0;
      end else if (!ecc_en) begin
         m_ph = 0; m_done = 0;
      end else begin
         case (m_ph)
            0: if (start) begin
                  int b;
                  b = int'(cfg_addr_bits);
                  if (b == 0 || b > MAXW) b = MAXW;
                  m_last = (1 << b) - 1;
                  m_addr = 0;
                  m_ph = 1;
               end
            1: if (cmd_gnt) begin
                  if (m_addr == m_last) begin
                     m_done = 1; m_addr = 0;
                     m_tmr = gap_of(int'(cfg_period)) - 1; m_ph = 2;
                  end else m_addr++;
               end
            2: if (m_tmr == 0) m_ph = 3; else m_tmr--;
            3: if (cmd_gnt) m_ph = 4;
            4: if (rd_valid) begin
                  if (rd_double) begin m_ue++; m_ph = 6; end
                  else if (rd_single) begin m_ce++; m_ph = 5; end
                  else m_ph = 6;
               end
            5: if (cmd_gnt) m_ph = 6;
            default: ;
         endcase
         if (m_ph == 6) begin
            if (m_addr == m_last) begin m_addr = 0; m_pass++; end
            else m_addr++;
            m_tmr = gap_of(int'(cfg_period)) - 1;
            m_ph = 2;
         end
      end
   end

   // Grant and response driver
   int gcnt = 0, lat = 0, rk = 0;
   int script[8] = '{0, 1, 0, 2, 0, 3, 1, 0};

   always @(negedge clk) begin
      gcnt++;
      rd_valid = 0; rd_single = 0; rd_double = 0;
      if (lat > 0) begin
         lat--;
         if (lat == 0) begin
            rd_valid  = 1;
            rd_single = (script[rk % 8] == 1) || (script[rk % 8] == 3);
            rd_double = (script[rk % 8] >= 2);
            rk++;
         end
      end
      cmd_gnt = cmd_req && ((gcnt % 3) != 1);
      if (cmd_gnt && !cmd_write) lat = 3;
   end

   // Per-cycle comparison against the reference
   function automatic string tag_of(input int ph);
      case (ph)
         0: return "R1";
         1: return "R2";
         2: return "R5";
         3: return "R6";
         4: return "R8";
         default: return "R7";
      endcase
   endfunction

   bit compare_on = 0;
   always @(negedge clk) begin
      if (rst_n && compare_on) begin
         string t;
         t = tag_of(m_ph);
         chk(t, "cmd_req", int'(cmd_req), int'(m_ph == 1 || m_ph == 3 || m_ph == 5));
         if (cmd_req) begin
            chk(t, "cmd_write", int'(cmd_write), int'(m_ph != 3));
            chk(t, "cmd_addr", int'(cmd_addr), m_addr);
         end
         chk("R4", "init_done", int'(init_done), int'(m_done));
         chk("R7", "ce_count", int'(ce_count), m_ce);
         chk("R9", "ue_count", int'(ue_count), m_ue);
         chk("R10", "pass_count", int'(pass_count), m_pass);
      end
   end

   // Port-level count of granted fill writes
   int wcnt = 0;
   always @(posedge clk) begin
      if (cmd_req && cmd_write && cmd_gnt && !init_done) wcnt++;
   end

   int cyc = 0;
   always @(posedge clk) begin
      cyc++;
      if (cyc > WATCHDOG && !finished) begin
         finished = 1;
         n_checks++; n_fail++;
         $display("FAIL watchdog: actual=%0d expected=%0d", cyc, WATCHDOG);
         $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
         $finish;
      end
   end

   task automatic run_fill(input logic [SW-1:0] bits, input int expect_writes, input string tag);
      ecc_en = 0;
      repeat (3) @(negedge clk);
      cfg_addr_bits = bits;
      wcnt = 0;
      ecc_en = 1;
      start = 1;
      @(negedge clk);
      start = 0;
      for (int i = 0; i < 4000 && !init_done; i++) @(negedge clk);
      chk(tag, "fill writes", wcnt, expect_writes);
      chk("R4", "init_done after fill", int'(init_done), 1);
   endtask

   initial begin
      repeat (5) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      // R11: reset values
      chk("R11", "cmd_req", int'(cmd_req), 0);
      chk("R11", "init_done", int'(init_done), 0);
      chk("R11", "ce_count", int'(ce_count), 0);
      chk("R11", "ue_count", int'(ue_count), 0);
      chk("R11", "pass_count", int'(pass_count), 0);
      compare_on = 1;
      // R1: start ignored while disabled
      start = 1;
      @(negedge clk);
      start = 0;
      repeat (20) @(negedge clk);
      chk("R1", "no request while disabled", int'(cmd_req), 0);
      // Main run: 8 locations, period 1
      cfg_addr_bits = 4'd3;
      wcnt = 0;
      ecc_en = 1;
      start = 1;
      @(negedge clk);
      start = 0;
      repeat (6000) @(negedge clk);
      chk("R3", "fill writes with 3 bits", wcnt, 8);
      chk("R10", "passes completed", int'(pass_count >= 2), 1);
      cfg_period = 8'd2;
      repeat (5000) @(negedge clk);
      cfg_period = 8'd0;
      repeat (300) @(negedge clk);
      chk("R7", "correctable seen", int'(ce_count > 0), 1);
      chk("R9", "uncorrectable seen", int'(ue_count > 0), 1);
      // R1: dropping enable mid-run
      ecc_en = 0;
      @(negedge clk);
      chk("R1", "req after disable", int'(cmd_req), 0);
      chk("R1", "init_done after disable", int'(init_done), 0);
      cfg_period = 8'd1;
      // R3: zero and oversized settings walk the full width
      run_fill(4'd0, 1 << MAXW, "R3");
      repeat (600) @(negedge clk);
      run_fill(4'd12, 1 << MAXW, "R3");
      repeat (600) @(negedge clk);
      if (!finished) begin
         finished = 1;
         $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
         $finish;
      end
   end

endmodule